// File: doc/BRIEF.md
# Frequency-Locked Loop Controller

This block keeps a digitally controlled oscillator on frequency. A slow reference clock is divided by 16 to make a measurement gate. The block counts fast-clock cycles in each gate period and compares that count with a programmed target of set value plus one. After each comparison it moves an 18-bit oscillator control code by at most one step, toward the target. There is no loop filter. The code is only ever nudged, so it follows slow drift and never jumps.

Clearing the enable stops correction. The oscillator then runs on the held code, which keeps its value. When the loop is enabled again, correction resumes from that held code, so there is no settling period. The first measurement after enable covers only part of a gate period, so it is thrown away. A new set value is first used for the gate period that starts at the next gate boundary. Each new code appears with a one-cycle strobe.

Top module: `freq_lock_loop`

## Requirements
- R1: While reset is asserted and after its release, the control code equals the `CODE_RESET` parameter and the update strobe is low until the first comparison.
- R2: The measurement gate is the reference divided by 16. Consecutive comparisons while enabled are exactly 16 reference periods apart.
- R3: When the fast-cycle count of a gate period is lower than set value + 1, the code rises by exactly one.
- R4: When the count is higher than set value + 1, the code falls by exactly one.
- R5: When the count equals set value + 1, the code is unchanged, and the update strobe still pulses.
- R6: The code saturates. A decrement at zero leaves it at zero, and an increment at all ones leaves it at all ones. It never wraps.
- R7: While the enable is low, the update strobe stays low, the code holds its value, and the cycle counter is held clear.
- R8: After the enable rises, the first gate edge only arms the loop. The first comparison uses the first full gate period.
- R9: A set value sampled at a gate boundary applies to the period that begins there. The comparison at that boundary still uses the value sampled one boundary earlier.
- R10: The new code and a one-cycle strobe appear together one fast-clock cycle after each comparison. The code never changes while the strobe is low.
- R11: With an oscillator whose frequency follows the code, the loop settles to the code whose frequency gives a count of set value + 1, within a few steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Slow reference clock (nominally 32.768 kHz) |
| fastClk | input | 1 | Oscillator clock being measured; clocks the loop logic |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| loopEn | input | 1 | Loop correction enable, synchronous to fastClk |
| setValue | input | 13 | Target count minus one per gate period |
| ctrlCode | output | 18 | Oscillator control code |
| codeStrobe | output | 1 | One-cycle pulse when a comparison result is presented |

## Verification
The bench runs the fast clock at a rate locked to the reference, so every gate period holds exactly 64 cycles and each expected code can be worked out ahead of time. It starts the code at 2 and steps it down against a low target, which tests saturation at zero: a wrapping design would jump to all ones. It changes the target right after a strobe, so a design that applied the new value one boundary early would step the wrong way once. It re-enables the loop in the middle of a gate period with a target equal to the true count, so a design that kept the partial count would step up when it should hold. A last phase feeds the code back into the clock period and checks that the loop settles near the predicted code.

// File: rtl/freq_lock_pkg.sv
package freq_lock_pkg;
  // Control-to-datapath strobes, all in the fast-clock domain.
  typedef struct packed {
    logic hold;      // loop stopped: keep counter clear
    logic boundary;  // synchronized gate edge this cycle
    logic measure;   // this boundary closes a valid full period
  } fllStrobes_t;
endpackage

// File: rtl/freq_lock_gate_div.sv
module freq_lock_gate_div #(
  parameter int DIV_LOG2 = 4
) (
  input  logic refClk,
  input  logic rstN,
  output logic gateOut
);
  logic [DIV_LOG2-1:0] divCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  // MSB toggles once per 2^(DIV_LOG2-1) reference cycles: period 2^DIV_LOG2.
  assign gateOut = divCnt[DIV_LOG2-1];
endmodule

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl
  import freq_lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        fastClk,
  input  logic        rstN,
  input  logic        gateIn,
  input  logic        loopEn,
  output fllStrobes_t strobes
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] syncQ;
  logic               gateEdge;
  logic               armed;

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[CHAIN_W-2:0], gateIn};
  end

  assign gateEdge = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  // The first edge after enable only arms; it closes a partial period.
  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN)         armed <= 1'b0;
    else if (!loopEn)  armed <= 1'b0;
    else if (gateEdge) armed <= 1'b1;
  end

  always_comb begin
    strobes.hold     = ~loopEn;
    strobes.boundary = gateEdge;
    strobes.measure  = gateEdge & loopEn & armed;
  end

  assert_edge_pulse_R2: assert property (@(posedge fastClk) disable iff (!rstN)
    strobes.boundary |=> !strobes.boundary);

  assert_first_edge_discard_R8: assert property (@(posedge fastClk) disable iff (!rstN)
    $rose(loopEn) |-> !strobes.measure);
endmodule

// File: rtl/freq_lock_datapath.sv
module freq_lock_datapath
  import freq_lock_pkg::*;
#(
  parameter int              CODE_W     = 18,
  parameter int              SET_W      = 13,
  parameter logic [CODE_W-1:0] CODE_RESET = '0
) (
  input  logic              fastClk,
  input  logic              rstN,
  input  fllStrobes_t       strobes,
  input  logic [SET_W-1:0]  setValue,
  output logic [CODE_W-1:0] ctrlCode,
  output logic              codeStrobe
);
  localparam int              CNT_W    = SET_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CNT_W-1:0]  cycleCnt;
  logic [CNT_W-1:0]  measCount;
  logic [CNT_W-1:0]  cmpTarget;
  logic [SET_W-1:0]  periodTarget;
  logic              cmpValid;
  logic [CODE_W-1:0] codeQ;
  logic [CODE_W-1:0] nextCode;
  logic              strobeQ;
  logic              countLow;
  logic              countHigh;

  // Cycle counter: a boundary cycle starts a new period as cycle one.
  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN)                   cycleCnt <= '0;
    else if (strobes.hold)       cycleCnt <= '0;
    else if (strobes.boundary)   cycleCnt <= CNT_W'(1);
    else if (cycleCnt != CNT_MAX) cycleCnt <= cycleCnt + 1'b1;
  end

  // Capture count and the target of the period just closed; sample new target.
  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      measCount    <= '0;
      cmpTarget    <= '0;
      periodTarget <= '0;
      cmpValid     <= 1'b0;
    end else begin
      cmpValid <= strobes.measure;
      if (strobes.boundary) begin
        measCount    <= cycleCnt;
        cmpTarget    <= CNT_W'(periodTarget) + 1'b1;
        periodTarget <= setValue;
      end
    end
  end

  assign countLow  = measCount < cmpTarget;
  assign countHigh = measCount > cmpTarget;

  always_comb begin
    nextCode = codeQ;
    if (countLow && codeQ != CODE_MAX)   nextCode = codeQ + 1'b1;
    else if (countHigh && codeQ != '0)   nextCode = codeQ - 1'b1;
  end

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      codeQ   <= CODE_RESET;
      strobeQ <= 1'b0;
    end else begin
      strobeQ <= cmpValid;
      if (cmpValid) codeQ <= nextCode;
    end
  end

  assign ctrlCode   = codeQ;
  assign codeStrobe = strobeQ;

  assert_small_step_R3: assert property (@(posedge fastClk) disable iff (!rstN)
    codeStrobe |-> (ctrlCode == $past(ctrlCode)) ||
                   (ctrlCode == $past(ctrlCode) + 1'b1) ||
                   ($past(ctrlCode) == ctrlCode + 1'b1));

  assert_no_wrap_low_R6: assert property (@(posedge fastClk) disable iff (!rstN)
    ($past(ctrlCode) == '0) |-> (ctrlCode != CODE_MAX));

  assert_no_wrap_high_R6: assert property (@(posedge fastClk) disable iff (!rstN)
    ($past(ctrlCode) == CODE_MAX) |-> (ctrlCode != '0));

  assert_code_with_strobe_R10: assert property (@(posedge fastClk) disable iff (!rstN)
    !codeStrobe |-> $stable(ctrlCode));

  assert_strobe_follows_compare_R10: assert property (@(posedge fastClk) disable iff (!rstN)
    cmpValid |=> codeStrobe);
endmodule

// File: rtl/freq_lock_loop.sv
module freq_lock_loop
  import freq_lock_pkg::*;
#(
  parameter int                CODE_W       = 18,
  parameter int                SET_W        = 13,
  parameter int                REF_DIV_LOG2 = 4,
  parameter int                SYNC_STAGES  = 2,
  parameter logic [CODE_W-1:0] CODE_RESET   = CODE_W'(1) << (CODE_W - 1)
) (
  input  logic              refClk,
  input  logic              fastClk,
  input  logic              rstN,
  input  logic              loopEn,
  input  logic [SET_W-1:0]  setValue,
  output logic [CODE_W-1:0] ctrlCode,
  output logic              codeStrobe
);
  logic        gateSig;
  fllStrobes_t strobes;

  freq_lock_gate_div #(.DIV_LOG2(REF_DIV_LOG2)) uGateDiv (
    .refClk (refClk),
    .rstN   (rstN),
    .gateOut(gateSig)
  );

  freq_lock_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .fastClk(fastClk),
    .rstN   (rstN),
    .gateIn (gateSig),
    .loopEn (loopEn),
    .strobes(strobes)
  );

  freq_lock_datapath #(
    .CODE_W    (CODE_W),
    .SET_W     (SET_W),
    .CODE_RESET(CODE_RESET)
  ) uDatapath (
    .fastClk   (fastClk),
    .rstN      (rstN),
    .strobes   (strobes),
    .setValue  (setValue),
    .ctrlCode  (ctrlCode),
    .codeStrobe(codeStrobe)
  );

  assert_idle_no_strobe_R7: assert property (@(posedge fastClk) disable iff (!rstN)
    (!$past(loopEn) && !$past(loopEn, 2)) |-> !codeStrobe);
endmodule

// File: tb/tb_freq_lock_loop.sv
`timescale 1ns/1ps
module tb_freq_lock_loop;
  localparam int CODE_W = 18;
  localparam int SET_W  = 13;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int GATE_CYC = 64;

  logic              refClk, fastClk, rstN, loopEn;
  logic [SET_W-1:0]  setValue;
  logic [CODE_W-1:0] ctrlCode;
  logic              codeStrobe;

  int  nChecks = 0, nFails = 0;
  bit  closedLoop = 0, scoreOn = 1, finished = 0;
  int  expCode = 2;
  int  cycleNum = 0, lastStrobeCyc = -1000;
  logic [CODE_W-1:0] expQ[$];
  logic [CODE_W-1:0] prevCode;
  logic              prevStrobe;

  freq_lock_loop #(.CODE_W(CODE_W), .SET_W(SET_W), .CODE_RESET(18'd2)) dut (
    .refClk(refClk), .fastClk(fastClk), .rstN(rstN), .loopEn(loopEn),
    .setValue(setValue), .ctrlCode(ctrlCode), .codeStrobe(codeStrobe)
  );

  // 50 MHz fast clock; in the closed-loop phase its period follows the code.
  initial begin
    fastClk = 0;
    forever begin
      if (!closedLoop) #10;
      else begin
        int halfPs;
        halfPs = 10000 - (int'(ctrlCode) - 5) * 40;
        if (halfPs < 2000) halfPs = 2000;
        #(halfPs / 1000.0);
      end
      fastClk = ~fastClk;
    end
  end

  // Reference offset by 5 ns so its edges never meet fast-clock edges.
  initial begin
    refClk = 0;
    #5;
    forever #40 refClk = ~refClk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: push expected codes for n comparisons at a given target.
  task automatic pushSteps(input int n, input int tgt);
    for (int i = 0; i < n; i++) begin
      if (GATE_CYC < tgt + 1)      expCode = (expCode == CODE_MAX) ? expCode : expCode + 1;
      else if (GATE_CYC > tgt + 1) expCode = (expCode == 0) ? 0 : expCode - 1;
      expQ.push_back(CODE_W'(expCode));
    end
  endtask

  task automatic waitDrain();
    wait (expQ.size() == 0);
    @(negedge fastClk);
  endtask

  // Monitor / scoreboard, sampling on the falling edge.
  always @(negedge fastClk) begin
    if (rstN) begin
      cycleNum++;
      if (!codeStrobe && ctrlCode != prevCode)
        check(0, "R10 code moved without strobe", int'(ctrlCode), int'(prevCode));
      if (codeStrobe && prevStrobe)
        check(0, "R10 strobe longer than one cycle", 2, 1);
      if (codeStrobe && scoreOn) begin
        if (expQ.size() == 0)
          check(0, "R7/R8 unexpected update strobe", int'(ctrlCode), -1);
        else begin
          logic [CODE_W-1:0] e;
          e = expQ.pop_front();
          check(ctrlCode == e, "R3/R4/R5/R6/R9 code after comparison", int'(ctrlCode), int'(e));
        end
        if (cycleNum - lastStrobeCyc < 200)
          check(cycleNum - lastStrobeCyc == GATE_CYC, "R2 comparison spacing",
                cycleNum - lastStrobeCyc, GATE_CYC);
      end
      if (codeStrobe) lastStrobeCyc = cycleNum;
    end
    prevCode   = ctrlCode;
    prevStrobe = codeStrobe;
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #3ms;
    check(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    rstN = 0; loopEn = 0; setValue = 13'd40;
    repeat (5) @(negedge fastClk);
    check(ctrlCode == 18'd2, "R1 reset code", int'(ctrlCode), 2);
    check(codeStrobe == 1'b0, "R1 reset strobe", int'(codeStrobe), 0);
    rstN = 1;
    repeat (3) @(negedge fastClk);
    check(ctrlCode == 18'd2 && !codeStrobe, "R1 code after release", int'(ctrlCode), 2);

    // R4, R6: count 64 above target 41, stepping down from 2 into the floor.
    pushSteps(5, 40);
    loopEn = 1;
    waitDrain();
    check(ctrlCode == 18'd0, "R6 saturated at zero", int'(ctrlCode), 0);

    // R9, R3: new target right after a strobe; one comparison still uses the old one.
    setValue = 13'd100;
    pushSteps(1, 40);
    pushSteps(4, 100);
    waitDrain();
    check(ctrlCode == 18'd4, "R3 rising code", int'(ctrlCode), 4);

    // R5: target equal to the count holds the code.
    setValue = 13'd63;
    pushSteps(1, 100);
    pushSteps(3, 63);
    waitDrain();
    check(ctrlCode == 18'd5, "R5 code held at equal count", int'(ctrlCode), 5);

    // R7: disabled loop gives no strobe and holds the code.
    loopEn = 0;
    repeat (310) @(negedge fastClk);
    check(ctrlCode == 18'd5, "R7 code held while disabled", int'(ctrlCode), 5);
    check(cycleNum - lastStrobeCyc >= 300, "R7 no strobe while disabled",
          cycleNum - lastStrobeCyc, 310);

    // R8: enable mid-period; a kept partial count would step the code up.
    loopEn = 1;
    pushSteps(3, 63);
    waitDrain();
    check(ctrlCode == 18'd5, "R8 partial period discarded", int'(ctrlCode), 5);

    // R11: closed loop, oscillator period follows the code.
    scoreOn = 0;
    setValue = 13'd69;
    closedLoop = 1;
    #80us;
    @(negedge fastClk);
    check(ctrlCode >= 18'd24 && ctrlCode <= 18'd30, "R11 settled code", int'(ctrlCode), 27);
    #20us;
    @(negedge fastClk);
    check(ctrlCode >= 18'd24 && ctrlCode <= 18'd30, "R11 code stays settled", int'(ctrlCode), 27);
    finishRun();
  end
endmodule